// File: doc/BRIEF.md
# Pipelined Single-Bit Reader for a Wide Register

This block reads one bit out of a very wide register without building a single multiplexer that spans every bit. The register is viewed as a grid of rows, 34 rows of 32 bits by default, and a bit address is split into a row index and a column index. The row index is taken from the upper address bits and the column index from the lower bits.

In the first pipeline stage the addressed row is copied into an intermediate row register. The column index is registered alongside it, so that the two stay together. In the second stage the column index picks the bit out of that held row.

Each selection is therefore only as wide as a row count or a row width, which shortens the longest combinational path of the read. The cost is one extra cycle of latency. A new address may be presented on every cycle, and results come out in the same order two cycles later. An address whose row index lies beyond the last row is reported as an error and returns zero.

Top module: `wide_bit_reader`

## Requirements
- R1: While reset is held and on the first sample after it is released, `bit_valid`, `bit_out` and `bit_err` are all 0.
- R2: A request taken at clock edge k (with `rd_valid`=1) produces `bit_valid`=1 exactly at edge k+2, and not at edge k+1.
- R3: The address maps as bit index = row*32 + column, with row = `rd_addr[10:5]` and column = `rd_addr[4:0]`. `bit_out` equals `reg_flat[rd_addr]`, where bit 0 of `reg_flat` is bit 0 of row 0.
- R4: Requests may arrive on consecutive cycles with no gap. Each result belongs to its own address, in issue order.
- R5: The returned bit reflects `reg_flat` as it stood at the edge where the request was taken. Changes to `reg_flat` on later cycles do not alter that result.
- R6: A request whose row index is 34 or more (address 1088 to 2047) returns `bit_valid`=1, `bit_err`=1 and `bit_out`=0. In-range requests return `bit_err`=0.
- R7: A cycle with `rd_valid`=0 yields `bit_valid`=0, `bit_out`=0 and `bit_err`=0 two cycles later. Idle gaps do not disturb the results that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request strobe |
| rd_addr | input | 11 | Bit address: row in [10:5], column in [4:0] |
| reg_flat | input | 1088 | Contents of the wide register, row 0 in the low bits |
| bit_valid | output | 1 | Result valid, two cycles after the request |
| bit_out | output | 1 | Selected bit (0 on error or idle) |
| bit_err | output | 1 | Row index out of range for this result |

## Verification
A sweep of every legal address, one per cycle, shows whether the row and column fields are split and weighted correctly. It also shows whether the column index stays aligned with its row through the pipeline. Random addresses with random idle gaps separate latency errors and slot misalignment from plain selection errors.

Inverting the whole register on the cycle after a request tells apart a design that samples the row at request time from one that reads it a cycle late. Addresses on both sides of the 1087/1088 boundary, and at the top of the address range, exercise the error flag and the forced-zero result.

// File: rtl/wbr_pkg.sv
`timescale 1ns/1ps
package wbr_pkg;
  localparam int DEF_ROW_W  = 32;
  localparam int DEF_ROWS   = 34;
  localparam int DEF_ADDR_W = 11;

  // Stage-one payload carried between the row fetch and the column pick.
  typedef struct packed {
    logic valid;
    logic err;
  } s1_flags_t;
endpackage

// File: rtl/wbr_row_fetch.sv
`timescale 1ns/1ps
module wbr_row_fetch
  import wbr_pkg::*;
#(
  parameter int ROW_W    = DEF_ROW_W,
  parameter int NUM_ROWS = DEF_ROWS,
  parameter int ADDR_W   = DEF_ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [ROW_W*NUM_ROWS-1:0] reg_flat,
  output s1_flags_t                 s1_flags,
  output logic [ROW_W-1:0]          s1_row,
  output logic [$clog2(ROW_W)-1:0]  s1_col
);
  localparam int COL_W     = $clog2(ROW_W);
  localparam int ROW_IDX_W = ADDR_W - COL_W;

  logic [ROW_W-1:0]     rows [NUM_ROWS];
  logic [ROW_IDX_W-1:0] row_idx;
  logic [COL_W-1:0]     col_idx;
  logic [ROW_W-1:0]     row_sel;
  logic                 row_bad;

  // Slice the flat register into rows.
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rows
    assign rows[r] = reg_flat[r*ROW_W +: ROW_W];
  end

  assign row_idx = req_addr[ADDR_W-1:COL_W];
  assign col_idx = req_addr[COL_W-1:0];
  assign row_bad = (row_idx >= ROW_IDX_W'(NUM_ROWS));

  // Row-wide selection: one NUM_ROWS-way mux per column bit.
  always_comb begin
    row_sel = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      if (row_idx == ROW_IDX_W'(r)) row_sel = rows[r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_flags <= '0;
      s1_row   <= '0;
      s1_col   <= '0;
    end else begin
      s1_flags.valid <= req_valid;
      s1_flags.err   <= req_valid & row_bad;
      if (req_valid) begin
        s1_row <= row_sel;
        s1_col <= col_idx;
      end
    end
  end

  // R6
  s1_err_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    s1_flags.err |-> s1_flags.valid);

  // R2
  s1_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> s1_flags.valid);
endmodule

// File: rtl/wbr_col_pick.sv
`timescale 1ns/1ps
module wbr_col_pick
  import wbr_pkg::*;
#(
  parameter int ROW_W = DEF_ROW_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  s1_flags_t                s1_flags,
  input  logic [ROW_W-1:0]         s1_row,
  input  logic [$clog2(ROW_W)-1:0] s1_col,
  output logic                     bit_valid,
  output logic                     bit_out,
  output logic                     bit_err
);
  logic picked;

  assign picked = s1_row[s1_col];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
      bit_err   <= 1'b0;
    end else begin
      bit_valid <= s1_flags.valid;
      bit_err   <= s1_flags.valid & s1_flags.err;
      bit_out   <= s1_flags.valid & ~s1_flags.err & picked;
    end
  end

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |-> (!bit_out && !bit_err));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> (bit_valid && !bit_out));
endmodule

// File: rtl/wide_bit_reader.sv
`timescale 1ns/1ps
module wide_bit_reader
  import wbr_pkg::*;
#(
  parameter int ROW_W    = DEF_ROW_W,
  parameter int NUM_ROWS = DEF_ROWS,
  parameter int ADDR_W   = DEF_ADDR_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_valid,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [ROW_W*NUM_ROWS-1:0] reg_flat,
  output logic                      bit_valid,
  output logic                      bit_out,
  output logic                      bit_err
);
  localparam int COL_W     = $clog2(ROW_W);
  localparam int ROW_IDX_W = ADDR_W - COL_W;

  s1_flags_t        s1_flags;
  logic [ROW_W-1:0] s1_row;
  logic [COL_W-1:0] s1_col;

  wbr_row_fetch #(
    .ROW_W(ROW_W), .NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk(clk), .rst(rst),
    .req_valid(rd_valid), .req_addr(rd_addr), .reg_flat(reg_flat),
    .s1_flags(s1_flags), .s1_row(s1_row), .s1_col(s1_col)
  );

  wbr_col_pick #(
    .ROW_W(ROW_W)
  ) u_pick (
    .clk(clk), .rst(rst),
    .s1_flags(s1_flags), .s1_row(s1_row), .s1_col(s1_col),
    .bit_valid(bit_valid), .bit_out(bit_out), .bit_err(bit_err)
  );

  // R2
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ##2 bit_valid);

  // R7
  idle_two_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> ##2 !bit_valid);

  // R6
  range_err_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && (rd_addr[ADDR_W-1:COL_W] >= ROW_IDX_W'(NUM_ROWS)))
      |-> ##2 (bit_err && !bit_out));

  // R6
  range_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && (rd_addr[ADDR_W-1:COL_W] < ROW_IDX_W'(NUM_ROWS)))
      |-> ##2 !bit_err);
endmodule

// File: tb/tb_wide_bit_reader.sv
`timescale 1ns/1ps
module tb_wide_bit_reader;
  localparam int W = 1088;

  logic          clk = 1'b0;
  logic          rst;
  logic          rd_valid;
  logic [10:0]   rd_addr;
  logic [W-1:0]  reg_flat;
  logic          bit_valid, bit_out, bit_err;

  logic [W-1:0]  ref_reg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected-result pipeline, two slots deep
  logic p1_v, p1_e, p1_b, p2_v, p2_e, p2_b;
  string p1_tag, p2_tag;

  always #2.5 clk = ~clk;

  wide_bit_reader dut (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .reg_flat(reg_flat), .bit_valid(bit_valid), .bit_out(bit_out),
    .bit_err(bit_err)
  );

  function automatic logic exp_bit(input logic [W-1:0] r, input logic [10:0] a);
    if (a < 11'd1088) return r[a];
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic v, input logic e, input logic b);
    checks++;
    if ({bit_valid, bit_err, bit_out} !== {v, e, b}) begin
      errors++;
      $display("FAIL %s: valid/err/out = %b%b%b expected %b%b%b",
               tag, bit_valid, bit_err, bit_out, v, e, b);
    end
  endtask

  // One cycle: check the result due now, then issue the next request.
  task automatic step(input string tag, input logic v, input logic [10:0] a);
    @(negedge clk);
    check(p2_tag, p2_v, p2_e, p2_b);
    p2_v = p1_v; p2_e = p1_e; p2_b = p1_b; p2_tag = p1_tag;
    rd_valid = v;
    rd_addr  = a;
    reg_flat = ref_reg;
    p1_v   = v;
    p1_e   = v && (a >= 11'd1088);
    p1_b   = v ? exp_bit(ref_reg, a) : 1'b0;
    p1_tag = tag;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < W / 32; i++) ref_reg[i*32 +: 32] = $urandom;
    rst = 1'b1; rd_valid = 1'b0; rd_addr = '0; reg_flat = ref_reg;
    p1_v = 0; p1_e = 0; p1_b = 0; p2_v = 0; p2_e = 0; p2_b = 0;
    p1_tag = "R7"; p2_tag = "R7";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b0);      // during reset
    rst = 1'b0;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, 1'b0);      // first sample after release

    // R2: isolated requests; idle slots around them must stay quiet
    step("R2", 1'b1, 11'd37);
    step("R7", 1'b0, 11'd0);
    step("R7", 1'b0, 11'd0);
    step("R2", 1'b1, 11'd1087);
    step("R7", 1'b0, 11'd5);

    // R3: full sweep of every legal address, back to back
    for (int a = 0; a < 1088; a++) step("R3", 1'b1, 11'(a));

    // R5: invert the register right after a request
    step("R5", 1'b1, 11'd100);
    ref_reg = ~ref_reg;
    step("R5", 1'b1, 11'd100);
    ref_reg = ~ref_reg;
    step("R5", 1'b1, 11'd100);
    step("R7", 1'b0, 11'd0);

    // R6: boundary and top of range
    step("R6", 1'b1, 11'd1087);
    step("R6", 1'b1, 11'd1088);
    step("R6", 1'b1, 11'd2047);
    step("R6", 1'b1, 11'd1089);
    step("R6", 1'b1, 11'd0);

    // R4: random stream with random idle gaps and occasional bad rows
    for (int n = 0; n < 3000; n++) begin
      logic [10:0] a;
      logic v;
      v = ($urandom_range(0, 3) != 0);
      a = ($urandom_range(0, 9) == 0) ? 11'($urandom_range(1088, 2047))
                                       : 11'($urandom_range(0, 1087));
      if (n % 500 == 0) ref_reg[$urandom_range(0, W-1)] ^= 1'b1;
      step("R4", v, a);
    end

    // drain
    step("R7", 1'b0, 11'd0);
    step("R7", 1'b0, 11'd0);
    step("R7", 1'b0, 11'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule